// File: doc/BRIEF.md
# Tamper Security State Controller

This block holds the security state of a battery-backed secure timekeeping unit. Ten detection inputs (supply voltage, slow clock, temperature, security alarm, external boot, external tamper A, external tamper B, wire mesh, monotonic-counter overflow and timer-counter overflow) each set a sticky detect flag. A per-source enable decides whether that flag forces the unit into the failure state. A flag that is set while its enable is clear is only reported and counts as spurious. Two sticky flags, non-valid and violation, make up a four-state machine: VALID (neither set), INVALID (non-valid only), FAILURE (violation only) and COMBINED (both set).

Software reaches three registers through a simple single-cycle write bus with a combinational read. The status register at address 0 holds the detect flags, the state flags and a write-error flag. All of them clear when 1 is written to their bit. The tamper-enable register is at address 1 and the control register, which holds the lock bits, is at address 2. Address 3 reads as zero. The unit runs its updates from a slow clock, so after an accepted write, further writes are refused for a fixed number of slow-clock ticks. The battery-domain reset (`bat_rst_n`) restores everything. The system reset (`sys_rst_n`) clears only the soft lock and moves a failed unit to COMBINED. The non-valid output feeds the separate timekeeping counter.

State transitions:
- Battery reset goes to INVALID.
- Tamper trigger: VALID goes to FAILURE and INVALID goes to COMBINED.
- Violation clear: FAILURE goes to VALID and COMBINED goes to INVALID.
- Non-valid clear: INVALID goes to VALID.
- System reset taken in FAILURE goes to COMBINED.
- A tamper trigger wins over any clear in the same cycle.

Top module: `sec_tamper_ctrl`

## Requirements
- R1: A low `bat_rst_n` clears all detect flags, enables, lock bits and the write-error flag, and puts the unit in INVALID. After it, the status register reads 0x0000_0400, and the tamper-enable and control registers read 0.
- R2: A high `det_in[i]` in a cycle sets status bit i (i = 0..9) at that clock edge. The bit stays set whatever its enable. With its enable bit clear, it never sets the violation flag.
- R3: If any status bit i is set together with tamper-enable bit i, the violation flag (status bit 11) is set at the next clock edge. VALID becomes FAILURE and INVALID becomes COMBINED.
- R4: An accepted status write clears each detect flag whose data bit is 1. A detection in the same cycle keeps that flag set.
- R5: An accepted status write with bit 11 set clears the violation flag only when all ten detect flags were already clear before the write. Otherwise the flag stays set.
- R6: An accepted status write with bit 10 set clears the non-valid flag only when the violation flag is clear.
- R7: Writing 1 to control bit 0 sets the soft lock and writing 1 to control bit 1 sets the hard lock. Writing 0 to either bit leaves it unchanged. While either lock is set, writes to the tamper-enable register have no effect.
- R8: A low `sys_rst_n` clears the soft lock and leaves the hard lock, the failure hard lock, the enables and the detect flags unchanged.
- R9: A low `sys_rst_n` taken in FAILURE moves the unit to COMBINED. Bus writes while `sys_rst_n` is low are ignored.
- R10: Writing 1 to control bit 2 sets the failure hard lock. While it is set, the violation flag cannot be cleared by a write, and only `bat_rst_n` removes it.
- R11: An accepted write starts a guard of GUARD_TICKS `slow_tick` pulses. A write during the guard is dropped and sets the write-error flag (status bit 12). That flag is cleared by an accepted status write with bit 12 set.
- R12: `nonvalid_o` and `violation_o` always equal status bits 10 and 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| bat_rst_n | input | 1 | Battery-domain reset, asynchronous, active low |
| sys_rst_n | input | 1 | System reset event, synchronous, active low |
| slow_tick | input | 1 | One-cycle pulse per slow-clock period |
| det_in | input | 10 | Detection event inputs, one per source |
| bus_wr | input | 1 | Single-cycle register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| nonvalid_o | output | 1 | Non-valid flag, to the timekeeping counter |
| violation_o | output | 1 | Violation flag |

## Verification
The assertions take for granted that `det_in`, `bus_wr` and `sys_rst_n` are synchronous to `clk` and that `bat_rst_n` is held low from time zero. They also assume a write strobe lasts one cycle per intended write. The bench drives every input at the falling edge and holds each system reset low for a single cycle. Random addresses stay in the two-bit space, including the unused one. Battery resets come at fixed intervals, so a unit stuck behind the failure hard lock is restored within each run of random traffic.

// File: rtl/sec_tamper_pkg.sv
package sec_tamper_pkg;

    localparam int N_SRC = 10;

    // status bit positions above the detect flags
    localparam int BIT_NV   = N_SRC;
    localparam int BIT_VIO  = N_SRC + 1;
    localparam int BIT_WERR = N_SRC + 2;

    // register addresses
    localparam logic [1:0] ADDR_STATUS = 2'd0;
    localparam logic [1:0] ADDR_TEN    = 2'd1;
    localparam logic [1:0] ADDR_CTRL   = 2'd2;

    // control bit positions
    localparam int CTL_SOFT = 0;
    localparam int CTL_HARD = 1;
    localparam int CTL_FHL  = 2;

    // bit 0 = non-valid, bit 1 = violation
    typedef enum logic [1:0] {
        ST_VALID    = 2'b00,
        ST_INVALID  = 2'b01,
        ST_FAILURE  = 2'b10,
        ST_COMBINED = 2'b11
    } sec_state_e;

endpackage

// File: rtl/sec_wr_guard.sv
module sec_wr_guard #(
    parameter int GUARD_TICKS = 4
) (
    input  logic clk,
    input  logic bat_rst_n,
    input  logic slow_tick,
    input  logic wr_req,
    output logic wr_accept,
    output logic wr_drop,
    output logic busy_o
);
    localparam int CW = $clog2(GUARD_TICKS + 1);

    logic [CW-1:0] cnt_q;

    assign busy_o    = (cnt_q != '0);
    assign wr_accept = wr_req & ~busy_o;
    assign wr_drop   = wr_req & busy_o;

    always_ff @(posedge clk or negedge bat_rst_n) begin
        if (!bat_rst_n)
            cnt_q <= '0;
        else if (wr_accept)
            cnt_q <= CW'(GUARD_TICKS);
        else if (slow_tick && busy_o)
            cnt_q <= cnt_q - 1'b1;
    end
endmodule

// File: rtl/sec_detect_bank.sv
module sec_detect_bank #(
    parameter int N = 10
) (
    input  logic         clk,
    input  logic         bat_rst_n,
    input  logic [N-1:0] det_in,
    input  logic [N-1:0] clr_mask,
    output logic [N-1:0] flags_q
);
    for (genvar i = 0; i < N; i++) begin : g_src
        always_ff @(posedge clk or negedge bat_rst_n) begin
            if (!bat_rst_n)
                flags_q[i] <= 1'b0;
            else
                flags_q[i] <= (flags_q[i] & ~clr_mask[i]) | det_in[i];
        end
    end
endmodule

// File: rtl/sec_state_fsm.sv
module sec_state_fsm
    import sec_tamper_pkg::*;
(
    input  logic clk,
    input  logic bat_rst_n,
    input  logic sys_rst_n,
    input  logic trig,
    input  logic vio_clr_req,
    input  logic nv_clr_req,
    input  logic flags_pending,
    input  logic fail_hard_lock,
    output logic nonvalid_o,
    output logic violation_o
);
    sec_state_e state_q, state_d;
    logic       vio_clr_ok;

    assign vio_clr_ok = vio_clr_req & ~flags_pending & ~fail_hard_lock;

    always_ff @(posedge clk or negedge bat_rst_n) begin
        if (!bat_rst_n)
            state_q <= ST_INVALID;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (!sys_rst_n) begin
            unique case (state_q)
                ST_VALID:    state_d = trig ? ST_FAILURE : ST_VALID;
                ST_INVALID:  state_d = trig ? ST_COMBINED : ST_INVALID;
                ST_FAILURE:  state_d = ST_COMBINED;
                ST_COMBINED: state_d = ST_COMBINED;
                default:     state_d = ST_INVALID;
            endcase
        end else begin
            unique case (state_q)
                ST_VALID:    if (trig) state_d = ST_FAILURE;
                ST_INVALID: begin
                    if (trig)            state_d = ST_COMBINED;
                    else if (nv_clr_req) state_d = ST_VALID;
                end
                ST_FAILURE:  if (!trig && vio_clr_ok) state_d = ST_VALID;
                ST_COMBINED: if (!trig && vio_clr_ok) state_d = ST_INVALID;
                default:     state_d = ST_INVALID;
            endcase
        end
    end

    always_comb begin
        unique case (state_q)
            ST_VALID:    begin nonvalid_o = 1'b0; violation_o = 1'b0; end
            ST_INVALID:  begin nonvalid_o = 1'b1; violation_o = 1'b0; end
            ST_FAILURE:  begin nonvalid_o = 1'b0; violation_o = 1'b1; end
            ST_COMBINED: begin nonvalid_o = 1'b1; violation_o = 1'b1; end
            default:     begin nonvalid_o = 1'b1; violation_o = 1'b0; end
        endcase
    end
endmodule

// File: rtl/sec_tamper_ctrl.sv
module sec_tamper_ctrl
    import sec_tamper_pkg::*;
#(
    parameter int GUARD_TICKS = 4
) (
    input  logic              clk,
    input  logic              bat_rst_n,
    input  logic              sys_rst_n,
    input  logic              slow_tick,
    input  logic [N_SRC-1:0]  det_in,
    input  logic              bus_wr,
    input  logic [1:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              nonvalid_o,
    output logic              violation_o
);
    logic             wr_req, wr_accept, wr_drop, guard_busy;
    logic             acc_status, acc_ten, acc_ctrl;
    logic [N_SRC-1:0] det_flags, ten_q, clr_mask;
    logic             soft_q, hard_q, fhl_q, werr_q;
    logic             trig;

    assign wr_req     = bus_wr & sys_rst_n;
    assign acc_status = wr_accept & (bus_addr == ADDR_STATUS);
    assign acc_ten    = wr_accept & (bus_addr == ADDR_TEN);
    assign acc_ctrl   = wr_accept & (bus_addr == ADDR_CTRL);
    assign clr_mask   = acc_status ? bus_wdata[N_SRC-1:0] : '0;
    assign trig       = |(det_flags & ten_q);

    sec_wr_guard #(.GUARD_TICKS(GUARD_TICKS)) u_guard (
        .clk       (clk),
        .bat_rst_n (bat_rst_n),
        .slow_tick (slow_tick),
        .wr_req    (wr_req),
        .wr_accept (wr_accept),
        .wr_drop   (wr_drop),
        .busy_o    (guard_busy)
    );

    sec_detect_bank #(.N(N_SRC)) u_bank (
        .clk       (clk),
        .bat_rst_n (bat_rst_n),
        .det_in    (det_in),
        .clr_mask  (clr_mask),
        .flags_q   (det_flags)
    );

    sec_state_fsm u_fsm (
        .clk            (clk),
        .bat_rst_n      (bat_rst_n),
        .sys_rst_n      (sys_rst_n),
        .trig           (trig),
        .vio_clr_req    (acc_status & bus_wdata[BIT_VIO]),
        .nv_clr_req     (acc_status & bus_wdata[BIT_NV]),
        .flags_pending  (|det_flags),
        .fail_hard_lock (fhl_q),
        .nonvalid_o     (nonvalid_o),
        .violation_o    (violation_o)
    );

    // tamper enables, frozen by either lock
    always_ff @(posedge clk or negedge bat_rst_n) begin
        if (!bat_rst_n)
            ten_q <= '0;
        else if (acc_ten && !soft_q && !hard_q)
            ten_q <= bus_wdata[N_SRC-1:0];
    end

    // soft lock: released by system reset
    always_ff @(posedge clk or negedge bat_rst_n) begin
        if (!bat_rst_n)
            soft_q <= 1'b0;
        else if (!sys_rst_n)
            soft_q <= 1'b0;
        else if (acc_ctrl && bus_wdata[CTL_SOFT])
            soft_q <= 1'b1;
    end

    // hard locks: released by battery reset only
    always_ff @(posedge clk or negedge bat_rst_n) begin
        if (!bat_rst_n) begin
            hard_q <= 1'b0;
            fhl_q  <= 1'b0;
        end else if (acc_ctrl) begin
            hard_q <= hard_q | bus_wdata[CTL_HARD];
            fhl_q  <= fhl_q  | bus_wdata[CTL_FHL];
        end
    end

    always_ff @(posedge clk or negedge bat_rst_n) begin
        if (!bat_rst_n)
            werr_q <= 1'b0;
        else
            werr_q <= (werr_q & ~(acc_status & bus_wdata[BIT_WERR])) | wr_drop;
    end

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            ADDR_STATUS: begin
                bus_rdata[N_SRC-1:0] = det_flags;
                bus_rdata[BIT_NV]    = nonvalid_o;
                bus_rdata[BIT_VIO]   = violation_o;
                bus_rdata[BIT_WERR]  = werr_q;
            end
            ADDR_TEN:  bus_rdata[N_SRC-1:0] = ten_q;
            ADDR_CTRL: begin
                bus_rdata[CTL_SOFT] = soft_q;
                bus_rdata[CTL_HARD] = hard_q;
                bus_rdata[CTL_FHL]  = fhl_q;
            end
            default:   bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/sec_tamper_chk.sv
module sec_tamper_chk
    import sec_tamper_pkg::*;
(
    input logic             clk,
    input logic             bat_rst_n,
    input logic             sys_rst_n,
    input logic             bus_wr,
    input logic             guard_busy,
    input logic [N_SRC-1:0] det_flags,
    input logic [N_SRC-1:0] ten_q,
    input logic             soft_q,
    input logic             hard_q,
    input logic             fhl_q,
    input logic             werr_q,
    input logic             nonvalid_o,
    input logic             violation_o
);
    assert_tamper_fail_R3: assert property (@(posedge clk) disable iff (!bat_rst_n)
        (|(det_flags & ten_q)) |=> violation_o);

    assert_pending_hold_R5: assert property (@(posedge clk) disable iff (!bat_rst_n)
        (violation_o && (det_flags != '0)) |=> violation_o);

    assert_nv_hold_R6: assert property (@(posedge clk) disable iff (!bat_rst_n)
        (violation_o && nonvalid_o) |=> nonvalid_o);

    assert_lock_freeze_R7: assert property (@(posedge clk) disable iff (!bat_rst_n)
        (soft_q || hard_q) |=> $stable(ten_q));

    assert_soft_release_R8: assert property (@(posedge clk) disable iff (!bat_rst_n)
        !sys_rst_n |=> !soft_q);

    assert_hard_keep_R8: assert property (@(posedge clk) disable iff (!bat_rst_n)
        hard_q |=> hard_q);

    assert_sys_combined_R9: assert property (@(posedge clk) disable iff (!bat_rst_n)
        (!sys_rst_n && violation_o) |=> (violation_o && nonvalid_o));

    assert_fhl_hold_R10: assert property (@(posedge clk) disable iff (!bat_rst_n)
        (fhl_q && violation_o) |=> violation_o);

    assert_drop_err_R11: assert property (@(posedge clk) disable iff (!bat_rst_n)
        (bus_wr && sys_rst_n && guard_busy) |=> werr_q);
endmodule

bind sec_tamper_ctrl sec_tamper_chk u_chk (
    .clk         (clk),
    .bat_rst_n   (bat_rst_n),
    .sys_rst_n   (sys_rst_n),
    .bus_wr      (bus_wr),
    .guard_busy  (guard_busy),
    .det_flags   (det_flags),
    .ten_q       (ten_q),
    .soft_q      (soft_q),
    .hard_q      (hard_q),
    .fhl_q       (fhl_q),
    .werr_q      (werr_q),
    .nonvalid_o  (nonvalid_o),
    .violation_o (violation_o)
);

// File: tb/sim_sec_tamper_ctrl.sv
module sim_sec_tamper_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int GT = 4;

    logic        clk = 1'b0;
    logic        bat_rst_n = 1'b0;
    logic        sys_rst_n = 1'b1;
    logic        slow_tick = 1'b0;
    logic [9:0]  det_in = '0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        nonvalid_o, violation_o;

    int n_tests = 0;
    int n_fail  = 0;

    // reference state
    logic [9:0] m_flags, m_en;
    logic       m_nv, m_vio, m_err, m_soft, m_hard, m_fhl;
    int         m_g;

    always #(CLK_PERIOD/2) clk = ~clk;

    sec_tamper_ctrl #(.GUARD_TICKS(GT)) u0 (
        .clk(clk), .bat_rst_n(bat_rst_n), .sys_rst_n(sys_rst_n),
        .slow_tick(slow_tick), .det_in(det_in), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .nonvalid_o(nonvalid_o), .violation_o(violation_o)
    );

    function automatic logic [31:0] exp_read(input int a);
        case (a)
            0: exp_read = {19'b0, m_err, m_vio, m_nv, m_flags};
            1: exp_read = {22'b0, m_en};
            2: exp_read = {29'b0, m_fhl, m_hard, m_soft};
            default: exp_read = '0;
        endcase
    endfunction

    task automatic model_reset();
        m_flags = '0; m_en = '0; m_nv = 1'b1; m_vio = 1'b0;
        m_err = 1'b0; m_soft = 1'b0; m_hard = 1'b0; m_fhl = 1'b0; m_g = 0;
    endtask

    task automatic model_update(input logic wr, input logic [1:0] a, input logic [31:0] d,
                                input logic [9:0] det, input logic tick, input logic sysr);
        logic busy, acc, drop, trig, st;
        logic n_nv, n_vio;
        busy = (m_g != 0);
        acc  = wr && sysr && !busy;
        drop = wr && sysr && busy;
        trig = |(m_flags & m_en);
        st   = acc && (a == 2'd0);
        n_nv = m_nv; n_vio = m_vio;
        if (!sysr) begin
            n_vio = m_vio | trig;
            n_nv  = m_nv | m_vio;
        end else if (trig) begin
            n_vio = 1'b1;
        end else begin
            if (st && d[11] && m_flags == '0 && !m_fhl) n_vio = 1'b0;
            if (st && d[10] && !m_vio) n_nv = 1'b0;
        end
        if (acc && a == 2'd1 && !m_soft && !m_hard) m_en = d[9:0];
        if (!sysr) m_soft = 1'b0;
        else if (acc && a == 2'd2 && d[0]) m_soft = 1'b1;
        if (acc && a == 2'd2) begin
            m_hard = m_hard | d[1];
            m_fhl  = m_fhl | d[2];
        end
        m_err   = (m_err & ~(st & d[12])) | drop;
        m_flags = (m_flags & ~(st ? d[9:0] : 10'b0)) | det;
        if (acc) m_g = GT;
        else if (tick && busy) m_g = m_g - 1;
        m_nv = n_nv; m_vio = n_vio;
    endtask

    task automatic step(input logic wr, input logic [1:0] a, input logic [31:0] d,
                        input logic [9:0] det, input logic tick, input logic sysr);
        bus_wr = wr; bus_addr = a; bus_wdata = d; det_in = det;
        slow_tick = tick; sys_rst_n = sysr;
        @(posedge clk);
        model_update(wr, a, d, det, tick, sysr);
        @(negedge clk);
        bus_wr = 1'b0; det_in = '0; slow_tick = 1'b0; sys_rst_n = 1'b1;
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        step(1'b1, a, d, '0, 1'b0, 1'b1);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 2'd0, '0, '0, 1'b1, 1'b1);
    endtask

    task automatic bat_reset();
        bat_rst_n = 1'b0;
        model_reset();
        @(negedge clk);
        bat_rst_n = 1'b1;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic check_all(input string req);
        for (int a = 0; a < 3; a++) begin
            bus_addr = 2'(a);
            #1;
            chk(req, bus_rdata, exp_read(a));
        end
        chk({req, "/R12"}, {30'b0, violation_o, nonvalid_o}, {30'b0, m_vio, m_nv});
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        bat_rst_n = 1'b1;
        // R1: reset values
        bus_addr = 2'd0; #1;
        chk("R1 status", bus_rdata, 32'h0000_0400);
        check_all("R1");

        // R6: leave INVALID
        wr(2'd0, 32'h400);
        check_all("R6 nv clear");
        // R11: write during guard dropped
        wr(2'd1, 32'h3FF);
        check_all("R11 drop");
        ticks(GT);
        wr(2'd0, 32'h1000);
        check_all("R11 err clear");
        ticks(GT);

        // R2: spurious event
        step(1'b0, 2'd0, '0, 10'h008, 1'b0, 1'b1);
        step(1'b0, 2'd0, '0, '0, 1'b0, 1'b1);
        chk("R2 spurious", {31'b0, violation_o}, 32'd0);
        check_all("R2");
        // R4: clear, and set-wins
        wr(2'd0, 32'h008);
        ticks(GT);
        step(1'b1, 2'd0, 32'h020, 10'h020, 1'b0, 1'b1);
        check_all("R4 set wins");
        ticks(GT);
        wr(2'd0, 32'h020);
        check_all("R4 clear");
        ticks(GT);

        // R3: enabled trigger
        wr(2'd1, 32'h080);
        ticks(GT);
        step(1'b0, 2'd0, '0, 10'h080, 1'b0, 1'b1);
        step(1'b0, 2'd0, '0, '0, 1'b0, 1'b1);
        chk("R3 fail", {30'b0, violation_o, nonvalid_o}, 32'd2);
        check_all("R3");
        // R5: refuse with pending flag, then clear
        wr(2'd0, 32'h800);
        check_all("R5 refuse");
        ticks(GT);
        wr(2'd0, 32'h080);
        ticks(GT);
        wr(2'd0, 32'h800);
        check_all("R5 clear");
        ticks(GT);

        // R7: soft lock freezes enables
        wr(2'd2, 32'h1);
        ticks(GT);
        wr(2'd1, 32'h000);
        check_all("R7 soft");
        ticks(GT);
        wr(2'd2, 32'h0);
        check_all("R7 zero no effect");
        ticks(GT);

        // R9/R8: failure then system reset
        step(1'b0, 2'd0, '0, 10'h080, 1'b0, 1'b1);
        step(1'b0, 2'd0, '0, '0, 1'b0, 1'b1);
        step(1'b1, 2'd1, 32'h0, '0, 1'b0, 1'b0);
        chk("R9 combined", {30'b0, violation_o, nonvalid_o}, 32'd3);
        check_all("R8 R9");
        // R6: combined refuses nv clear
        wr(2'd0, 32'h480);
        check_all("R6 refuse");
        ticks(GT);
        wr(2'd0, 32'h800);
        check_all("R5 to invalid");
        ticks(GT);
        wr(2'd0, 32'h400);
        check_all("R6 to valid");
        ticks(GT);

        // R7/R8: hard lock survives system reset
        wr(2'd2, 32'h2);
        step(1'b0, 2'd0, '0, '0, 1'b0, 1'b0);
        ticks(GT);
        wr(2'd1, 32'h3FF);
        check_all("R8 hard kept");
        ticks(GT);

        // R10: failure hard lock
        wr(2'd2, 32'h4);
        ticks(GT);
        step(1'b0, 2'd0, '0, 10'h080, 1'b0, 1'b1);
        step(1'b0, 2'd0, '0, '0, 1'b0, 1'b1);
        wr(2'd0, 32'h080);
        ticks(GT);
        wr(2'd0, 32'h800);
        chk("R10 stuck", {31'b0, violation_o}, 32'd1);
        check_all("R10");
        bat_reset();
        check_all("R1 again");

        // random traffic
        void'($urandom(32'd7321));
        for (int i = 0; i < 1200; i++) begin
            logic [31:0] d;
            logic [9:0]  det;
            d   = $urandom;
            det = (($urandom % 6) == 0) ? 10'(1 << ($urandom % 10)) : 10'b0;
            if (i % 300 == 299) bat_reset();
            step(($urandom % 3) == 0, 2'($urandom % 4), d, det,
                 ($urandom % 2) == 0, ($urandom % 40) != 0);
            if (i % 8 == 0) check_all("R2-random R4 R5 R11");
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule